// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a small memory-mapped bank of system control registers. Its configuration registers are shielded by a 16-bit key lock. It comes out of reset locked. Software must write an opening key to one offset before any configuration write is accepted, and can shut the bank again with a closing key written to a second offset. A read-only status word shows the lock state. A one-bit scratch control word at offset 0x000 stays writable at all times.

The configuration space holds three register groups, each with its own reset values:
- PLL settings, at 0x100 to 0x11C.
- Clock settings, at 0x120 to 0x16C.
- Reset settings, at 0x200 to 0x25C.

Inside these groups, two offsets refuse writes even when the bank is open. Any write the bank does not take raises a one-cycle error strobe. This covers a write while locked, a write to a protected or read-only offset, and a write to an unmapped or misaligned address. Reads are registered and return data one cycle after the request.

Top module: `keyreg_bank`

## Requirements
- R1: After reset the bank is locked. Offset 0x00C reads 1. The PLL control words at 0x100, 0x104 and 0x108 read 0x0001A008. The PLL status word at 0x10C reads 0x0000003F. The PLL configuration words at 0x110, 0x114 and 0x118 read 0x00014000. The clock words at 0x120, 0x124 and 0x128 read 0x1F000400, 0x18400003 and 0x01E03201. The reset-cause word at 0x24C reads 0x00000040. Every other configuration word reads 0.
- R2: A write to 0x004 whose bits [15:0] equal 0x767B locks the bank, whatever the upper bits hold. Any other value written there leaves the lock state unchanged.
- R3: A write to 0x008 whose bits [15:0] equal 0xDF0D opens the bank. Any other value written there leaves the lock state unchanged.
- R4: Reads of 0x004 and 0x008 return 0.
- R5: Offset 0x00C reads the lock state in bit 0 (1 = locked, other bits 0). A write to it changes nothing and raises the error strobe.
- R6: Offset 0x000 stores only bit 0 of the written value, reads it back in bit 0, and accepts writes whether locked or open.
- R7: While locked, every write at or above 0x100 is discarded and raises the error strobe.
- R8: While open, a write to a mapped configuration word stores all 32 bits, and a later read returns them.
- R9: Writes to 0x10C and 0x250 are rejected with the error strobe even while open, and the stored values are kept.
- R10: Offset 0x25C always reads 1. A write to it while open is accepted without error but does not change what it reads.
- R11: Unmapped or misaligned addresses read 0, and writes to them raise the error strobe. The unmapped addresses include 0x010 to 0x0FC, 0x170 to 0x1FC and everything above 0x25C.
- R12: Read data appears on the clock edge after a read request and is 0 in any cycle after which no read was requested. The error strobe is high for exactly the cycle after a rejected write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Byte offset of the access |
| we | input | 1 | Write request |
| wdata | input | 32 | Write data |
| re | input | 1 | Read request |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle strobe for a rejected write |

## Verification
The hardest situations to reach are where the lock state and the address holes interact. One example is a write to a protected offset while the bank is open. Another is a wrong-key write to a key offset, which must change nothing, followed at once by configuration writes. Directed sequences open and close the bank around these offsets. Constrained random traffic then mixes correct keys, near-miss keys, hole addresses and mapped words, so that every group is reached in both lock states. A bench model predicts each read value and each error strobe.

// File: rtl/keyreg_pkg.sv
// Shared constants and reset-value functions for the key-protected register bank.
// Assumes a 12-bit byte address space with 32-bit word registers.
package keyreg_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned KEY_W  = 16;
    localparam int unsigned WORD_W = ADDR_W - 2;

    localparam logic [KEY_W-1:0]  KEY_CLOSE = 16'h767B;
    localparam logic [KEY_W-1:0]  KEY_OPEN  = 16'hDF0D;

    localparam logic [ADDR_W-1:0] OFF_SCRATCH = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CLOSE   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_OPEN    = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_STATE   = 12'h00C;
    localparam logic [ADDR_W-1:0] CFG_FLOOR   = 12'h100;

    typedef enum logic [1:0] {GRP_PLL, GRP_CLK, GRP_RST} grp_e;

    // Reset value of entry idx of group g.
    function automatic logic [DATA_W-1:0] grp_reset_value(grp_e g, int idx);
        logic [DATA_W-1:0] v;
        v = '0;
        case (g)
            GRP_PLL: begin
                if (idx <= 2)                  v = 32'h0001A008;
                else if (idx == 3)             v = 32'h0000003F;
                else if (idx >= 4 && idx <= 6) v = 32'h00014000;
            end
            GRP_CLK: begin
                if (idx == 0)      v = 32'h1F000400;
                else if (idx == 1) v = 32'h18400003;
                else if (idx == 2) v = 32'h01E03201;
            end
            default: begin
                if (idx == 19) v = 32'h00000040;
            end
        endcase
        return v;
    endfunction

    // Entries that refuse writes even when the bank is open.
    function automatic logic grp_write_blocked(grp_e g, int idx);
        return (g == GRP_PLL && idx == 3) || (g == GRP_RST && idx == 20);
    endfunction

    // Entries whose read value is fixed at one.
    function automatic logic grp_reads_one(grp_e g, int idx);
        return (g == GRP_RST && idx == 23);
    endfunction
endpackage

// File: rtl/keyreg_lock.sv
// Lock state machine: a closing key sets the lock and an opening key clears it.
// Assumes the caller qualifies close_wr and open_wr with the write address; at most one is high.
module keyreg_lock
    import keyreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_wr,
    input  logic             open_wr,
    input  logic [KEY_W-1:0] key,
    output logic             locked
);
    // Update the lock on a matching key, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                               locked <= 1'b1;
        else if (close_wr && key == KEY_CLOSE)    locked <= 1'b1;
        else if (open_wr && key == KEY_OPEN)      locked <= 1'b0;
    end

    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> locked);
    assert_close_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(close_wr && key == KEY_CLOSE)) |-> locked);
    assert_open_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(open_wr && key == KEY_OPEN)) |-> !locked);
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!close_wr && !open_wr)) |-> $stable(locked));
endmodule

// File: rtl/keyreg_group.sv
// One contiguous group of configuration words with per-entry reset values.
// Assumes wr_open is already qualified by the write request and by the lock being open.
module keyreg_group
    import keyreg_pkg::*;
#(
    parameter grp_e GRP       = GRP_PLL,
    parameter int   BASE_WORD = 64,
    parameter int   COUNT     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_addr,
    input  logic              aligned,
    input  logic              wr_open,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic              blocked,
    output logic [DATA_W-1:0] rvalue
);
    logic [DATA_W-1:0] regs [COUNT];
    logic [COUNT-1:0]  sel;

    for (genvar i = 0; i < COUNT; i++) begin : g_entry
        // Entry select from the word address.
        assign sel[i] = aligned && (word_addr == WORD_W'(BASE_WORD + i));

        // Store an accepted write into this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= grp_reset_value(GRP, i);
            else if (wr_open && sel[i] && !grp_write_blocked(GRP, i))
                regs[i] <= wdata;
        end
    end

    // Hit, protection and read value of the selected entry.
    always_comb begin
        hit     = |sel;
        blocked = 1'b0;
        rvalue  = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (sel[i]) begin
                blocked = grp_write_blocked(GRP, i);
                rvalue  = grp_reads_one(GRP, i) ? DATA_W'(1) : regs[i];
            end
        end
    end
endmodule

// File: rtl/keyreg_bank.sv
// Key-protected control register bank: lock words at low offsets, three configuration
// groups above 0x100, registered reads and a one-cycle error strobe for rejected writes.
// Assumes a single access per cycle; a read in the same cycle as a write sees old data.
module keyreg_bank
    import keyreg_pkg::*;
#(
    parameter int PLL_WORDS = 8,
    parameter int CLK_WORDS = 20,
    parameter int RST_WORDS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    localparam int PLL_BASE = 'h100 / 4;
    localparam int CLK_BASE = PLL_BASE + PLL_WORDS;
    localparam int RST_BASE = 'h200 / 4;
    localparam int NGRP     = 3;

    logic              locked;
    logic              scratch;
    logic [WORD_W-1:0] word_addr;
    logic              aligned;
    logic              wr_open;
    logic [NGRP-1:0]   g_hit, g_blk;
    logic [DATA_W-1:0] g_val [NGRP];
    logic              cfg_hit, cfg_blk;
    logic [DATA_W-1:0] cfg_val, rd_next;
    logic              accept;

    assign word_addr = addr[ADDR_W-1:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign wr_open   = we && !locked;

    keyreg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .close_wr (we && addr == OFF_CLOSE),
        .open_wr  (we && addr == OFF_OPEN),
        .key      (wdata[KEY_W-1:0]),
        .locked   (locked)
    );

    keyreg_group #(.GRP(GRP_PLL), .BASE_WORD(PLL_BASE), .COUNT(PLL_WORDS)) u_pll (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .aligned(aligned),
        .wr_open(wr_open), .wdata(wdata), .hit(g_hit[0]), .blocked(g_blk[0]), .rvalue(g_val[0]));

    keyreg_group #(.GRP(GRP_CLK), .BASE_WORD(CLK_BASE), .COUNT(CLK_WORDS)) u_clk (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .aligned(aligned),
        .wr_open(wr_open), .wdata(wdata), .hit(g_hit[1]), .blocked(g_blk[1]), .rvalue(g_val[1]));

    keyreg_group #(.GRP(GRP_RST), .BASE_WORD(RST_BASE), .COUNT(RST_WORDS)) u_rst (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .aligned(aligned),
        .wr_open(wr_open), .wdata(wdata), .hit(g_hit[2]), .blocked(g_blk[2]), .rvalue(g_val[2]));

    // Merge the group outputs; groups never overlap, so an OR is enough.
    always_comb begin
        cfg_val = '0;
        for (int g = 0; g < NGRP; g++) cfg_val |= g_val[g];
        cfg_hit = |g_hit;
        cfg_blk = |(g_hit & g_blk);
    end

    // Read multiplexer for the low words and the configuration groups.
    always_comb begin
        case (addr)
            OFF_SCRATCH: rd_next = DATA_W'(scratch);
            OFF_STATE:   rd_next = DATA_W'(locked);
            default:     rd_next = cfg_hit ? cfg_val : '0;
        endcase
    end

    // Decide whether the current write is taken by any register.
    always_comb begin
        accept = (addr == OFF_SCRATCH) || (addr == OFF_CLOSE) || (addr == OFF_OPEN) ||
                 (cfg_hit && !locked && !cfg_blk);
    end

    // Scratch control word keeps bit 0 only, regardless of the lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                          scratch <= 1'b0;
        else if (we && addr == OFF_SCRATCH)  scratch <= wdata[0];
    end

    // Register read data and the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= re ? rd_next : '0;
            err   <= we && !accept;
        end
    end

    assert_locked_cfg_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we && addr >= CFG_FLOOR && locked)) |-> err);
    assert_key_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(re && (addr == OFF_CLOSE || addr == OFF_OPEN))) |-> rdata == '0);
    assert_fixed_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(re && addr == 12'h25C)) |-> rdata == DATA_W'(1));
    assert_hole_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we && (addr == 12'h10C || addr == 12'h250))) |-> err);
    assert_err_needs_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!we)) |-> !err);
    assert_state_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we && addr == OFF_STATE)) |-> err);
endmodule

// File: tb/tb_keyreg_bank.sv
// Self-checking bench: directed corner cases, then seeded random traffic against a model.
module tb_keyreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [31:0] mem [int];
    logic        m_locked;
    logic        m_scratch;

    keyreg_bank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
                     .re(re), .rdata(rdata), .err(err));

    always #5 clk = ~clk;

    function automatic bit is_cfg(logic [11:0] a);
        if (a[1:0] != 2'b00) return 0;
        return (a >= 12'h100 && a <= 12'h16C) || (a >= 12'h200 && a <= 12'h25C);
    endfunction

    function automatic bit is_blocked(logic [11:0] a);
        return a == 12'h10C || a == 12'h250;
    endfunction

    function automatic logic [31:0] reset_of(logic [11:0] a);
        if (a == 12'h100 || a == 12'h104 || a == 12'h108) return 32'h0001A008;
        if (a == 12'h10C) return 32'h0000003F;
        if (a == 12'h110 || a == 12'h114 || a == 12'h118) return 32'h00014000;
        if (a == 12'h120) return 32'h1F000400;
        if (a == 12'h124) return 32'h18400003;
        if (a == 12'h128) return 32'h01E03201;
        if (a == 12'h24C) return 32'h00000040;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == 12'h000) return {31'b0, m_scratch};
        if (a == 12'h00C) return {31'b0, m_locked};
        if (a == 12'h25C) return 32'h1;
        if (is_cfg(a))    return mem[int'(a)];
        return 32'h0;
    endfunction

    function automatic bit exp_err(logic [11:0] a);
        if (a == 12'h000 || a == 12'h004 || a == 12'h008) return 0;
        return !(is_cfg(a) && !m_locked && !is_blocked(a));
    endfunction

    task automatic model_reset();
        m_locked  = 1'b1;
        m_scratch = 1'b0;
        for (int a = 'h100; a <= 'h25C; a += 4) mem[a] = reset_of(12'(a));
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    // One access: drive at the falling edge, check registered outputs after the next rise.
    task automatic op(string tag, bit w, bit r, logic [11:0] a, logic [31:0] d);
        logic [31:0] er;
        bit          ee;
        @(negedge clk);
        addr = a; we = w; re = r; wdata = d;
        er = r ? exp_read(a) : 32'h0;
        ee = w && exp_err(a);
        @(posedge clk);
        #1;
        check(tag, rdata, er);
        check(tag, {31'b0, err}, {31'b0, ee});
        if (w) begin
            if (a == 12'h000) m_scratch = d[0];
            else if (a == 12'h004 && d[15:0] == 16'h767B) m_locked = 1'b1;
            else if (a == 12'h008 && d[15:0] == 16'hDF0D) m_locked = 1'b0;
            else if (is_cfg(a) && !m_locked && !is_blocked(a)) mem[int'(a)] = d;
        end
        we = 1'b0; re = 1'b0;
    endtask

    task automatic rd(string tag, logic [11:0] a);
        op(tag, 1'b0, 1'b1, a, 32'h0);
    endtask

    task automatic wr(string tag, logic [11:0] a, logic [31:0] d);
        op(tag, 1'b1, 1'b0, a, d);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [11:0] pool [16];
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240607);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd("R1 lock state", 12'h00C);
        rd("R1 pll ctl", 12'h104);
        rd("R1 pll status", 12'h10C);
        rd("R1 pll cfg", 12'h118);
        rd("R1 clk word", 12'h128);
        rd("R1 reset cause", 12'h24C);
        rd("R1 zero word", 12'h11C);
        // R7: locked writes discarded
        wr("R7 locked write", 12'h100, 32'hDEADBEEF);
        rd("R7 value kept", 12'h100);
        wr("R7 locked write rst", 12'h240, 32'h12345678);
        rd("R7 value kept rst", 12'h240);
        // R6: scratch bit 0 only, writable while locked
        wr("R6 scratch write", 12'h000, 32'hFFFFFFFF);
        rd("R6 scratch read", 12'h000);
        wr("R6 scratch clear", 12'h000, 32'hFFFFFFFE);
        rd("R6 scratch read0", 12'h000);
        // R3: wrong key then right key
        wr("R3 wrong key", 12'h008, 32'h0000DF0C);
        rd("R3 still locked", 12'h00C);
        wr("R3 open key", 12'h008, 32'hABCDDF0D);
        rd("R3 opened", 12'h00C);
        // R4: key words read zero
        rd("R4 close reads 0", 12'h004);
        rd("R4 open reads 0", 12'h008);
        // R8: open writes store
        wr("R8 pll write", 12'h100, 32'hA5A55A5A);
        rd("R8 pll read", 12'h100);
        wr("R8 clk write", 12'h16C, 32'h0F0F1234);
        rd("R8 clk read", 12'h16C);
        // R9: protected holes
        wr("R9 status hole", 12'h10C, 32'h0);
        rd("R9 status kept", 12'h10C);
        wr("R9 reset hole", 12'h250, 32'hFFFFFFFF);
        rd("R9 reset hole kept", 12'h250);
        // R10: fixed one
        rd("R10 reads one", 12'h25C);
        wr("R10 write accepted", 12'h25C, 32'h0);
        rd("R10 still one", 12'h25C);
        // R11: unmapped and misaligned
        rd("R11 low gap", 12'h010);
        wr("R11 low gap write", 12'h010, 32'h1);
        wr("R11 misaligned", 12'h102, 32'h1);
        rd("R11 upper gap", 12'h1F0);
        wr("R11 high write", 12'h800, 32'h1);
        // R5: state word is read-only
        wr("R5 state write", 12'h00C, 32'h1);
        rd("R5 state unchanged", 12'h00C);
        // R12: strobe lasts one cycle, idle read data zero
        op("R12 idle after reject", 1'b0, 1'b0, 12'h100, 32'h0);
        // R2: close with garbage upper bits, wrong close key
        wr("R2 wrong close", 12'h004, 32'h0000767A);
        rd("R2 still open", 12'h00C);
        wr("R2 close key", 12'h004, 32'hFFFF767B);
        rd("R2 closed", 12'h00C);
        wr("R7 after close", 12'h124, 32'h1);
        rd("R7 after close read", 12'h124);

        // Random traffic over a pool of interesting addresses (R8, R11, R2, R3).
        pool = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h100, 12'h10C, 12'h118, 12'h11C,
                 12'h120, 12'h16C, 12'h170, 12'h200, 12'h24C, 12'h250, 12'h25C, 12'h260};
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            int unsigned k;
            k = $urandom_range(0, 15);
            a = pool[k];
            if ($urandom_range(0, 9) == 0) a = 12'($urandom_range(0, 4095));
            d = $urandom();
            if (a == 12'h004 && $urandom_range(0, 1) == 1) d[15:0] = 16'h767B;
            if (a == 12'h008 && $urandom_range(0, 1) == 1) d[15:0] = 16'hDF0D;
            op("R8 R11 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule